// File: doc/BRIEF.md
# Linked-List Command Block Walker

This block follows a chain of command blocks held in a word-organised system memory and forwards each block's payload to a downstream command consumer. A walk begins with a one-cycle start pulse and a 24-bit start link. Each node begins with a header word. The header's low 24 bits give the link to the next node, and its top byte gives how many payload words follow the header. The walker reads the header, streams the payload words in order to the consumer, and then moves to the linked node. The walk ends when a link equals the all-ones terminator.

A list that points back into itself could make the walk run forever. To prevent this, every non-final header the walker visits is written back with link bit 23 set as a visit marker. If the walker later reads a header that carries this marker, it stops at that header. Once the walk has stopped, a second pass starts again from the start link and visits the same number of nodes, rewriting each header with the marker cleared. Memory then ends in the state it was in before the walk. The block then pulses `done`, and the total number of words it consumed (each header plus its payload) stays available on `word_total`.

Memory is reached through a single request/grant port. A request holds its address, direction and write data until it is granted. Read data is returned on the cycle after the grant.

Top module: `lldma_walker`

## Requirements
- R1: The payload words of each node are read from the word addresses directly after its header and are presented on the command port in memory order, one word per `cmd_valid`/`cmd_ready` handshake, with exactly the header's length count per node.
- R2: A link is converted to a memory word address by taking link bits 20:2, which masks the link to 0x1FFFFF. A memory request keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_gnt` is seen, and read data is taken on the cycle after the grant.
- R3: A link of 0xFFFFFF ends the walk. A start link of 0xFFFFFF completes with `word_total` = 0, delivers no payload and makes no memory request.
- R4: The payload length is header bits 31:24. A node with length zero delivers nothing and goes straight to its link.
- R5: During the walk, each visited header whose link is not the terminator is written back once with bit 23 set.
- R6: A header read during the walk that has bit 23 set and a link other than 0xFFFFFF stops the walk. That node delivers no payload and adds nothing to the total. A list that loops back to a visited node therefore ends at the revisit.
- R7: After `done`, every header marked during the walk holds its original value again, and no other memory word has been changed.
- R8: `word_total` equals the sum over all accepted nodes of 1 plus the length. It is cleared when a walk starts and holds its value while the block is idle.
- R9: `busy` is high from the cycle after an accepted start until `done`. `done` is a single-cycle pulse after the clearing pass. No memory request or command word is presented while the block is not busy.
- R10: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_data` does not change.
- R11: A start pulse while the block is busy is ignored, and the running walk completes with its original results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| start_addr | input | 24 | Link of the first node |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 19 | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid the cycle after a read grant |
| cmd_valid | output | 1 | Payload word available |
| cmd_data | output | 32 | Payload word |
| cmd_ready | input | 1 | Consumer accepts the word |
| busy | output | 1 | Walk or clearing pass in progress |
| done | output | 1 | One-cycle completion pulse |
| word_total | output | 32 | Words consumed by the last walk |

## Verification
The bench targets several corner cases, and each one shows up as a distinct failure if the design gets it wrong:

- **Two-node cycle.** If the marker is not written, or is misread, the walk never ends. If it stops one node late, the payload is repeated and the total is too large.
- **Header already carrying bit 23.** If this is not treated as a stop, foreign payload appears on the command port.
- **Links with high bits above the 2 MB mask.** A design that drops the masking issues addresses outside the populated region.
- **Zero-length nodes, a terminator start link, and a restart pulse during a walk.** These check for spurious or missing command words and a corrupted total.

After every walk, the whole memory is compared with its original image. This catches a clearing pass that visits the wrong number of nodes or clears the wrong bit.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

  typedef enum logic [3:0] {
    S_IDLE,   // waiting for start
    S_HRD,    // request header read
    S_HWAIT,  // header data returns
    S_MARK,   // write header back with marker
    S_PRD,    // request payload read
    S_PWAIT,  // payload data returns
    S_POUT,   // offer payload word downstream
    S_CINIT,  // set up clearing pass
    S_CRD,    // request header read (clearing)
    S_CWAIT,  // header data returns (clearing)
    S_CWR,    // write header back without marker
    S_FIN     // completion pulse
  } walk_st_e;

endpackage

// File: rtl/lldma_rst_sync.sv
module lldma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/lldma_hdr_decode.sv
module lldma_hdr_decode #(
  parameter int DATA_W = 32,
  parameter int LINK_W = 24,
  parameter int LEN_W  = 8,
  parameter int MEM_AW = 19
) (
  input  logic [DATA_W-1:0] hdr,
  output logic [LEN_W-1:0]  len,
  output logic [MEM_AW-1:0] word,
  output logic              is_term
);
  localparam logic [LINK_W-1:0] TERM = '1;

  assign len     = hdr[DATA_W-1 -: LEN_W];
  assign word    = hdr[MEM_AW+1:2];
  assign is_term = (hdr[LINK_W-1:0] == TERM);
endmodule

// File: rtl/lldma_tally.sv
module lldma_tally #(
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 8,
  parameter int NODE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add,
  input  logic [LEN_W-1:0]  len,
  output logic [CNT_W-1:0]  total,
  output logic [NODE_W-1:0] nodes
);
  logic [CNT_W-1:0]  total_d;
  logic [NODE_W-1:0] nodes_d;
  logic              upd_en;

  always_comb begin
    upd_en  = clr | add;
    total_d = clr ? '0 : total + CNT_W'(len) + CNT_W'(1);
    nodes_d = clr ? '0 : nodes + NODE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total <= '0;
      nodes <= '0;
    end else if (upd_en) begin
      total <= total_d;
      nodes <= nodes_d;
    end
  end
endmodule

// File: rtl/lldma_walker.sv
module lldma_walker
  import lldma_pkg::*;
#(
  parameter int LINK_W = 24,
  parameter int LEN_W  = 8,
  parameter int MEM_AW = 19,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int NODE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LINK_W-1:0] start_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_ready,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  word_total
);
  localparam int MARK_BIT = LINK_W - 1;
  localparam logic [LINK_W-1:0] TERM = '1;
  localparam logic [DATA_W-1:0] MARK_MASK = DATA_W'(1) << MARK_BIT;

  logic rst_n_i;

  walk_st_e          st_q, st_d;
  logic [MEM_AW-1:0] cur_q, cur_d, base_q, base_d, paddr_q, paddr_d;
  logic [DATA_W-1:0] hdr_q, hdr_d, cmd_q, cmd_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [NODE_W-1:0] left_q, left_d, nodes;
  logic              t_clr, t_add, advance;

  logic [LEN_W-1:0]  rd_len, hq_len;
  logic [MEM_AW-1:0] rd_word, hq_word;
  logic              rd_term, hq_term, rd_tagged;

  lldma_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  lldma_hdr_decode #(.DATA_W(DATA_W), .LINK_W(LINK_W), .LEN_W(LEN_W), .MEM_AW(MEM_AW))
    i_dec_rd (.hdr(mem_rdata), .len(rd_len), .word(rd_word), .is_term(rd_term));

  lldma_hdr_decode #(.DATA_W(DATA_W), .LINK_W(LINK_W), .LEN_W(LEN_W), .MEM_AW(MEM_AW))
    i_dec_hq (.hdr(hdr_q), .len(hq_len), .word(hq_word), .is_term(hq_term));

  lldma_tally #(.CNT_W(CNT_W), .LEN_W(LEN_W), .NODE_W(NODE_W))
    i_tally (.clk(clk), .rst_n(rst_n_i), .clr(t_clr), .add(t_add), .len(rd_len),
             .total(word_total), .nodes(nodes));

  assign rd_tagged = mem_rdata[MARK_BIT] & ~rd_term;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cur_d   = cur_q;
    base_d  = base_q;
    paddr_d = paddr_q;
    hdr_d   = hdr_q;
    cmd_d   = cmd_q;
    rem_d   = rem_q;
    left_d  = left_q;
    t_clr   = 1'b0;
    t_add   = 1'b0;
    advance = 1'b0;
    unique case (st_q)
      S_IDLE: if (start) begin
        t_clr  = 1'b1;
        base_d = start_addr[MEM_AW+1:2];
        cur_d  = start_addr[MEM_AW+1:2];
        st_d   = (start_addr == TERM) ? S_CINIT : S_HRD;
      end
      S_HRD:   if (mem_gnt) st_d = S_HWAIT;
      S_HWAIT: begin
        hdr_d = mem_rdata;
        if (rd_tagged) st_d = S_CINIT;
        else begin
          t_add   = 1'b1;
          rem_d   = rd_len;
          paddr_d = cur_q + MEM_AW'(1);
          if (rd_term) st_d = (rd_len != '0) ? S_PRD : S_CINIT;
          else         st_d = S_MARK;
        end
      end
      S_MARK: if (mem_gnt) begin
        if (hq_len != '0) st_d = S_PRD;
        else              advance = 1'b1;
      end
      S_PRD:   if (mem_gnt) st_d = S_PWAIT;
      S_PWAIT: begin
        cmd_d = mem_rdata;
        st_d  = S_POUT;
      end
      S_POUT: if (cmd_ready) begin
        rem_d   = rem_q - LEN_W'(1);
        paddr_d = paddr_q + MEM_AW'(1);
        if (rem_q == LEN_W'(1)) advance = 1'b1;
        else                    st_d = S_PRD;
      end
      S_CINIT: begin
        cur_d  = base_q;
        left_d = nodes;
        st_d   = (nodes == '0) ? S_FIN : S_CRD;
      end
      S_CRD:   if (mem_gnt) st_d = S_CWAIT;
      S_CWAIT: begin
        hdr_d = mem_rdata;
        st_d  = rd_term ? S_FIN : S_CWR;
      end
      S_CWR: if (mem_gnt) begin
        left_d = left_q - NODE_W'(1);
        cur_d  = hq_word;
        st_d   = (left_q == NODE_W'(1)) ? S_FIN : S_CRD;
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
    if (advance) begin
      if (hq_term) st_d = S_CINIT;
      else begin
        st_d  = S_HRD;
        cur_d = hq_word;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q    <= S_IDLE;
      cur_q   <= '0;
      base_q  <= '0;
      paddr_q <= '0;
      hdr_q   <= '0;
      cmd_q   <= '0;
      rem_q   <= '0;
      left_q  <= '0;
    end else begin
      st_q    <= st_d;
      cur_q   <= cur_d;
      base_q  <= base_d;
      paddr_q <= paddr_d;
      hdr_q   <= hdr_d;
      cmd_q   <= cmd_d;
      rem_q   <= rem_d;
      left_q  <= left_d;
    end
  end

  always_comb begin
    mem_req   = (st_q == S_HRD) || (st_q == S_MARK) || (st_q == S_PRD) ||
                (st_q == S_CRD) || (st_q == S_CWR);
    mem_we    = (st_q == S_MARK) || (st_q == S_CWR);
    mem_addr  = (st_q == S_PRD) ? paddr_q : cur_q;
    mem_wdata = (st_q == S_MARK) ? (hdr_q | MARK_MASK) : (hdr_q & ~MARK_MASK);
    cmd_valid = (st_q == S_POUT);
    cmd_data  = cmd_q;
    busy      = (st_q != S_IDLE);
    done      = (st_q == S_FIN);
  end
endmodule

// File: rtl/lldma_walker_chk.sv
module lldma_walker_chk #(
  parameter int LINK_W = 24,
  parameter int MEM_AW = 19,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [LINK_W-1:0] start_addr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_gnt,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              cmd_valid,
  input logic [DATA_W-1:0] cmd_data,
  input logic              cmd_ready,
  input logic              busy,
  input logic              done,
  input logic [CNT_W-1:0]  word_total
);
  a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !cmd_valid);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r8_total_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(word_total));

  a_r11_stay_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
endmodule

bind lldma_walker lldma_walker_chk #(
  .LINK_W(LINK_W), .MEM_AW(MEM_AW), .DATA_W(DATA_W), .CNT_W(CNT_W)
) i_chk (.*);

// File: tb/test_lldma_walker.sv
module test_lldma_walker;
  localparam int MW = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [23:0] start_addr;
  logic        mem_req, mem_we, mem_gnt, cmd_valid, cmd_ready, busy, done;
  logic [18:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata, cmd_data, word_total;

  always #4 clk = ~clk;

  lldma_walker i_lldma_walker (.*);

  logic [31:0] mem  [MW];
  logic [31:0] gold [MW];
  int tests = 0, fails = 0;
  int oob = 0, marks = 0, done_cnt = 0;
  logic [31:0] got[$];
  logic [31:0] expq[$];
  int exp_total, exp_marks;

  // memory and consumer model
  always @(posedge clk) begin
    mem_gnt   <= ($urandom % 4) != 0;
    cmd_ready <= ($urandom % 3) != 0;
    if (mem_req && mem_gnt) begin
      if (mem_addr >= 19'(MW)) oob <= oob + 1;
      else if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[9:0]];
    end
  end

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (cmd_valid && cmd_ready) got.push_back(cmd_data);
    if (mem_req && mem_gnt && mem_we && mem_wdata[23]) marks++;
    if (done) done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MW; i++) begin
      mem[i] = '0;
      gold[i] = '0;
    end
  endtask

  task automatic put_node(input int w, input logic [23:0] link, input int len);
    logic [31:0] h;
    h = {8'(len), link};
    mem[w] = h;
    gold[w] = h;
    for (int i = 1; i <= len; i++) begin
      h = $urandom;
      mem[w + i] = h;
      gold[w + i] = h;
    end
  endtask

  // reference walk over the untouched image
  task automatic model(input logic [23:0] sa);
    bit visited [MW];
    logic [23:0] cur;
    logic [31:0] h;
    int idx;
    expq.delete();
    exp_total = 0;
    exp_marks = 0;
    for (int i = 0; i < MW; i++) visited[i] = 1'b0;
    cur = sa;
    while (cur != 24'hFFFFFF) begin
      idx = int'(cur[20:2]);
      h = gold[idx];
      if (visited[idx] || (h[23] && h[23:0] != 24'hFFFFFF)) break;
      visited[idx] = 1'b1;
      exp_total += 1 + int'(h[31:24]);
      if (h[23:0] != 24'hFFFFFF) exp_marks++;
      for (int i = 1; i <= int'(h[31:24]); i++) expq.push_back(gold[idx + i]);
      cur = h[23:0];
    end
  endtask

  task automatic run(input logic [23:0] sa, input string req, input bit restart);
    int wait_n;
    int bad;
    model(sa);
    got.delete();
    marks = 0;
    done_cnt = 0;
    oob = 0;
    @(negedge clk);
    start = 1'b1;
    start_addr = sa;
    @(negedge clk);
    start = 1'b0;
    if (restart) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      start_addr = 24'hFFFFFF;
      @(negedge clk);
      start = 1'b0;
    end
    wait_n = 0;
    while (done_cnt == 0 && wait_n < 20000) begin
      @(negedge clk);
      wait_n++;
    end
    chk(done_cnt != 0, "R9", "walk completes", wait_n, 0);
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
    chk(!busy, "R9", "idle after done", busy, 0);
    chk(word_total == 32'(exp_total), "R8", "word total", word_total, exp_total);
    chk(got.size() == expq.size(), {req, " R1"}, "payload count", got.size(), expq.size());
    bad = 0;
    for (int i = 0; i < got.size() && i < expq.size(); i++)
      if (got[i] != expq[i]) bad++;
    chk(bad == 0, "R1", "payload mismatches", bad, 0);
    chk(marks == exp_marks, "R5", "marker writes", marks, exp_marks);
    bad = 0;
    for (int i = 0; i < MW; i++) if (mem[i] !== gold[i]) bad++;
    chk(bad == 0, "R7", "memory words altered", bad, 0);
    chk(oob == 0, "R2", "out of range accesses", oob, 0);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    start = 1'b0;
    start_addr = '0;
    clear_mem();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cmd_valid && !mem_req, "R9", "reset outputs quiet", busy, 0);
    chk(word_total == 0, "R8", "reset total", word_total, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3: terminator as start link
    clear_mem();
    run(24'hFFFFFF, "R3", 1'b0);
    chk(word_total == 0, "R3", "empty walk total", word_total, 0);

    // single node
    clear_mem();
    put_node(16, 24'hFFFFFF, 3);
    run(24'(16 * 4), "R1", 1'b0);

    // R4: zero-length node in chain
    clear_mem();
    put_node(32, 24'(48 * 4), 0);
    put_node(48, 24'hFFFFFF, 2);
    run(24'(32 * 4), "R4", 1'b0);
    chk(word_total == 32'd4, "R4", "zero-length total", word_total, 4);

    // R6: two-node loop
    clear_mem();
    put_node(64, 24'(80 * 4), 1);
    put_node(80, 24'(64 * 4), 2);
    run(24'(64 * 4), "R6", 1'b0);
    chk(word_total == 32'd5, "R6", "loop total", word_total, 5);

    // R2: links with bits above the mask
    clear_mem();
    put_node(96, 24'h600000 | 24'(112 * 4), 1);
    put_node(112, 24'hFFFFFF, 2);
    run(24'h400000 | 24'(96 * 4), "R2", 1'b0);
    chk(word_total == 32'd5, "R2", "aliased total", word_total, 5);

    // R6: pre-tagged header
    clear_mem();
    put_node(128, 24'(144 * 4), 2);
    put_node(144, 24'h800000 | 24'(160 * 4), 3);
    put_node(160, 24'hFFFFFF, 1);
    run(24'(128 * 4), "R6", 1'b0);
    chk(word_total == 32'd3, "R6", "tagged stop total", word_total, 3);

    // R11: restart while busy
    clear_mem();
    put_node(176, 24'(192 * 4), 6);
    put_node(192, 24'hFFFFFF, 4);
    run(24'(176 * 4), "R11", 1'b1);
    chk(word_total == 32'd12, "R11", "restart ignored total", word_total, 12);

    // random lists
    for (int t = 0; t < 25; t++) begin
      int n;
      int slot [6];
      clear_mem();
      n = 1 + int'($urandom % 6);
      for (int i = 0; i < n; i++) begin
        bit dup;
        do begin
          slot[i] = int'($urandom % 64);
          dup = 1'b0;
          for (int j = 0; j < i; j++) if (slot[j] == slot[i]) dup = 1'b1;
        end while (dup);
      end
      for (int i = 0; i < n; i++) begin
        logic [23:0] lk;
        if (i < n - 1) lk = 24'(slot[i + 1] * 64);
        else if ($urandom % 2) lk = 24'hFFFFFF;
        else lk = 24'(slot[$urandom % n] * 64);
        put_node(slot[i] * 16, lk, int'($urandom % 9));
      end
      run(24'(slot[0] * 64), "R1", 1'b0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule